// File: doc/BRIEF.md
# Masked Signature Compactor

This block folds a stream of test responses into a short signature held in a linear feedback shift register. The register divides by the characteristic polynomial 1 + x + x^4. In serial mode one response bit per cycle enters the first stage. In parallel mode every stage takes its own scan-chain bit along with the shifted and feedback terms. A gating stage in front of the register forces unknown response bits to a known zero. It uses either one mask bit shared by every chain or one mask bit per chain, and an input picks between the two.

A test session begins with a start pulse, which clears the register to all zeros. Response data then flows in on the cycles where the valid input is high. A done pulse compares the register with an expected signature that is supplied from outside. The pass/fail verdict is held, and the signature is frozen, until the next start pulse. Aliasing, where a faulty stream lands on the fault-free signature, is accepted as a property of the compactor and is not flagged.

Top module: `masked_sig_compactor`

## Requirements
- R1: After reset, signature is 0000, result_valid is 0 and pass is 0.
- R2: A start pulse clears the signature to 0000 and clears result_valid and pass on the next edge, whatever valid and done hold in that cycle.
- R3: The signature changes only on edges where valid is high. With valid low it holds its value.
- R4: In serial mode (par_mode=0), the bits 1,1,0,1,1,0,0,1 applied in that time order on ser_in after start give signature[0..3] = 1,0,1,1, which is signature = 4'b1101.
- R5: In serial mode the bits 1,1,0,1,0,0,0,1 in that time order give a signature different from 4'b1101.
- R6: In parallel mode (par_mode=1), each update makes stage i equal to stage i-1 (0 for stage 0), XOR stage 3 where the polynomial has a term (stages 0 and 1), XOR chain_in[i].
- R7: With mask_per_chain=0, mask_shared=0 forces every chain bit and the serial bit to 0, and mask_shared=1 passes them through unchanged.
- R8: With mask_per_chain=1, mask_vec[i] gates chain_in[i] in parallel mode, and mask_vec[0] gates ser_in in serial mode.
- R9: A done pulse while no result is held sets result_valid on the next edge, with pass=1 exactly when signature equals expected in the done cycle.
- R10: While result_valid is high and start is low, the signature, pass and result_valid hold, and further valid or done pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear signature to the all-zero seed and drop the verdict |
| valid | input | 1 | Response data is present this cycle |
| par_mode | input | 1 | 0 serial, 1 parallel compaction |
| mask_per_chain | input | 1 | 0 shared mask bit, 1 per-chain mask vector |
| mask_shared | input | 1 | Mask bit applied to all chains (1 passes) |
| mask_vec | input | 4 | Per-chain mask bits (1 passes) |
| ser_in | input | 1 | Serial response bit |
| chain_in | input | 4 | One response bit per scan chain |
| done | input | 1 | End of session: compare signature |
| expected | input | 4 | Fault-free signature to compare against |
| signature | output | 4 | Current signature, bit i is stage i |
| result_valid | output | 1 | Verdict held |
| pass | output | 1 | 1 when the signature matched expected |

## Verification
The bench builds the block with its default width of four stages and the polynomial mask 4'b0011. This puts the fault-free and faulty serial streams of R4 and R5 within reach with their known outcomes. A behavioural model does polynomial division on integers and is compared with the signature and verdict on every clock. The stimulus covers both compaction modes and both masking options, start pulses that collide with valid, and done pulses that arrive while a verdict is already held.

// File: rtl/msc_pkg.sv
package msc_pkg;
  typedef enum logic {
    MODE_SERIAL   = 1'b0,
    MODE_PARALLEL = 1'b1
  } msc_mode_e;
endpackage

// File: rtl/msc_xgate.sv
module msc_xgate
  import msc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  msc_mode_e        mode,
  input  logic             per_chain,
  input  logic             shared_en,
  input  logic [WIDTH-1:0] vec_en,
  input  logic             ser_bit,
  input  logic [WIDTH-1:0] chains,
  output logic [WIDTH-1:0] gated
);
  logic [WIDTH-1:0] lane_en;
  logic [WIDTH-1:0] raw;

  always_comb begin
    raw = '0;
    if (mode == MODE_PARALLEL) raw = chains;
    else                       raw[0] = ser_bit;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    assign lane_en[i] = per_chain ? vec_en[i] : shared_en;
    assign gated[i]   = raw[i] & lane_en[i];
  end
endmodule

// File: rtl/msc_lfsr.sv
module msc_lfsr #(
  parameter int               WIDTH = 4,
  parameter logic [WIDTH-1:0] POLY  = 4'b0011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] sig
);
  logic [WIDTH-1:0] sig_q, sig_d, shifted;
  logic             fb;

  assign fb = sig_q[WIDTH-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign shifted[i] = 1'b0;
    end else begin : g_rest
      assign shifted[i] = sig_q[i-1];
    end
  end

  always_comb begin
    sig_d = sig_q;
    if (clear)   sig_d = '0;
    else if (en) sig_d = shifted ^ (POLY & {WIDTH{fb}}) ^ din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_d;
  end

  assign sig = sig_q;

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clear) |=> $stable(sig_q));
  // R2
  seed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sig_q == '0));
endmodule

// File: rtl/msc_judge.sv
module msc_judge #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             done,
  input  logic [WIDTH-1:0] sig,
  input  logic [WIDTH-1:0] expected,
  output logic             freeze,
  output logic             res_valid,
  output logic             pass
);
  logic rv_q, rv_d, ps_q, ps_d, take;

  assign take = done && !rv_q;

  always_comb begin
    rv_d = rv_q;
    ps_d = ps_q;
    if (clear) begin
      rv_d = 1'b0;
      ps_d = 1'b0;
    end else if (take) begin
      rv_d = 1'b1;
      ps_d = (sig == expected);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      ps_q <= 1'b0;
    end else begin
      rv_q <= rv_d;
      ps_q <= ps_d;
    end
  end

  assign freeze    = rv_q | done;
  assign res_valid = rv_q;
  assign pass      = ps_q;

  // R9
  verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rv_q && !clear) |=> (rv_q && (ps_q == ($past(sig) == $past(expected)))));
  // R10
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && !clear) |=> (rv_q && $stable(ps_q)));
endmodule

// File: rtl/masked_sig_compactor.sv
module masked_sig_compactor
  import msc_pkg::*;
#(
  parameter int               WIDTH = 4,
  parameter logic [WIDTH-1:0] POLY  = 4'b0011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             valid,
  input  logic             par_mode,
  input  logic             mask_per_chain,
  input  logic             mask_shared,
  input  logic [WIDTH-1:0] mask_vec,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] chain_in,
  input  logic             done,
  input  logic [WIDTH-1:0] expected,
  output logic [WIDTH-1:0] signature,
  output logic             result_valid,
  output logic             pass
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;
  logic [WIDTH-1:0]       gated;
  logic                   freeze;
  logic                   upd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  msc_xgate #(.WIDTH(WIDTH)) u_gate (
    .mode      (msc_mode_e'(par_mode)),
    .per_chain (mask_per_chain),
    .shared_en (mask_shared),
    .vec_en    (mask_vec),
    .ser_bit   (ser_in),
    .chains    (chain_in),
    .gated     (gated)
  );

  assign upd_en = valid && !freeze;

  msc_lfsr #(.WIDTH(WIDTH), .POLY(POLY)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clear (start),
    .en    (upd_en),
    .din   (gated),
    .sig   (signature)
  );

  msc_judge #(.WIDTH(WIDTH)) u_judge (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clear     (start),
    .done      (done),
    .sig       (signature),
    .expected  (expected),
    .freeze    (freeze),
    .res_valid (result_valid),
    .pass      (pass)
  );

  // R10
  frozen_sig_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (result_valid && !start) |=> $stable(signature));
  // R7
  shared_block_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid && !start && !done && !result_valid && !mask_per_chain && !mask_shared
     && signature == '0) |=> (signature == '0));
endmodule

// File: tb/masked_sig_compactor_test.sv
module masked_sig_compactor_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 0, valid = 0, par_mode = 0, mask_per_chain = 0, mask_shared = 1;
  logic [3:0] mask_vec = 4'hF, chain_in = 0, expected = 0;
  logic       ser_in = 0, done = 0;
  logic [3:0] signature;
  logic       result_valid, pass;

  int n_vec = 0, n_bad = 0;
  int m_sig = 0, m_rv = 0, m_ps = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  masked_sig_compactor uut (
    .clk(clk), .rst_n(rst_n), .start(start), .valid(valid), .par_mode(par_mode),
    .mask_per_chain(mask_per_chain), .mask_shared(mask_shared), .mask_vec(mask_vec),
    .ser_in(ser_in), .chain_in(chain_in), .done(done), .expected(expected),
    .signature(signature), .result_valid(result_valid), .pass(pass)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural model: polynomial division by 1 + x + x^4
  task automatic model_edge();
    int d, en;
    if (par_mode) d = chain_in & (mask_per_chain ? mask_vec : (mask_shared ? 15 : 0));
    else          d = (ser_in & (mask_per_chain ? mask_vec[0] : mask_shared)) ? 1 : 0;
    if (start) begin
      m_sig = 0; m_rv = 0; m_ps = 0;
    end else begin
      en = valid && !m_rv && !done;
      if (done && !m_rv) begin
        m_rv = 1; m_ps = (m_sig == expected) ? 1 : 0;
      end
      if (en) m_sig = (((m_sig << 1) & 15) ^ (((m_sig >> 3) & 1) ? 3 : 0)) ^ d;
    end
  endtask

  task automatic cycle(input string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({req, " sig"}, signature, m_sig);
    chk({req, " rv"}, result_valid, m_rv);
    chk({req, " pass"}, pass, m_ps);
    start = 0; valid = 0; done = 0;
  endtask

  task automatic serial_stream(input logic [7:0] bits, input string req);
    for (int i = 7; i >= 0; i--) begin
      par_mode = 0; valid = 1; ser_in = bits[i];
      cycle(req);
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 sig", signature, 0);
    chk("R1 rv", result_valid, 0);
    chk("R1 pass", pass, 0);

    // R4 fault-free serial stream
    start = 1; cycle("R2");
    serial_stream(8'b11011001, "R4");
    chk("R4 signature", signature, 4'b1101);
    expected = 4'b1101; done = 1; cycle("R9");
    chk("R9 pass on match", pass, 1);
    // R10: more data and done while held
    valid = 1; ser_in = 1; cycle("R10");
    done = 1; expected = 0; cycle("R10");
    chk("R10 frozen sig", signature, 4'b1101);
    chk("R10 pass held", pass, 1);

    // R5 faulty stream; R2 start collides with valid
    start = 1; valid = 1; ser_in = 1; cycle("R2");
    chk("R2 seed zero", signature, 0);
    chk("R2 rv cleared", result_valid, 0);
    serial_stream(8'b11010001, "R5");
    chk("R5 differs", (signature != 4'b1101) ? 1 : 0, 1);
    expected = 4'b1101; done = 1; cycle("R9");
    chk("R9 fail on mismatch", pass, 0);
    chk("R9 rv set", result_valid, 1);

    // R6 parallel compaction
    start = 1; cycle("R2");
    par_mode = 1; valid = 1; chain_in = 4'b1010; cycle("R6");
    chk("R6 first load", signature, 4'b1010);
    par_mode = 1; valid = 1; chain_in = 4'b0000; cycle("R6");
    chk("R6 feedback", signature, 4'b0111);
    // R3 idle cycles
    chain_in = 4'b1111; cycle("R3"); cycle("R3");
    chk("R3 hold", signature, 4'b0111);

    // R7 shared mask blocks everything
    start = 1; cycle("R2");
    mask_shared = 0;
    for (int k = 0; k < 3; k++) begin
      par_mode = 1; valid = 1; chain_in = 4'b1111; cycle("R7");
    end
    chk("R7 blocked", signature, 0);
    par_mode = 0; valid = 1; ser_in = 1; cycle("R7");
    chk("R7 serial blocked", signature, 0);

    // R8 per-chain mask
    mask_per_chain = 1; mask_vec = 4'b0101;
    par_mode = 1; valid = 1; chain_in = 4'b1111; cycle("R8");
    chk("R8 per chain", signature, 4'b0101);
    start = 1; cycle("R2");
    mask_vec = 4'b1110; par_mode = 0; valid = 1; ser_in = 1; cycle("R8");
    chk("R8 serial gated", signature, 0);
    mask_vec = 4'b0001; par_mode = 0; valid = 1; ser_in = 1; cycle("R8");
    chk("R8 serial passed", signature, 1);

    // mixed patterns against model, R6 and R7
    mask_per_chain = 0; mask_shared = 1;
    for (int k = 0; k < 40; k++) begin
      par_mode = k[0]; valid = (k % 5) != 3; chain_in = 4'((k * 7) ^ (k >> 1));
      ser_in = k[1]; mask_shared = (k % 7) != 2;
      cycle("R6");
    end
    expected = signature; done = 1; cycle("R9");
    chk("R9 pass", pass, 1);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule